// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Sequencer

This block takes bytes from a serial receiver and stores them in memory buffers. A ring of buffer descriptors in memory describes those buffers. Each descriptor occupies eight bytes at an 8-byte stride from a programmable table base. The first 32-bit word holds a status halfword in the upper half and a received length in the lower half. The second word holds the buffer start address. The sequencer fetches a descriptor and takes it only if software marked it empty. It streams bytes into the buffer, one memory byte write per byte, and closes the buffer in one of two ways. It closes it on reaching the maximum buffer length, or earlier when a byte arrives tagged end-of-frame or error. On closing, it writes the status and length back in a single word and moves to the next descriptor. After a descriptor carrying the wrap flag, it returns to the table base.

The maximum length is copied into the working limit each time a descriptor is taken. Rewriting it while the receiver runs therefore only affects later buffers. The table base can only be changed while the receiver is off. Enabling is refused, with a configuration error shown, for a misaligned base, a zero length, or an odd length when characters are wider than 8 bits. When the next descriptor is still owned by software, the block shows busy. It then accepts and discards incoming bytes and keeps polling until the descriptor is handed back.

Top module: `rx_bd_seq`

## Requirements
- R1: A buffer closes when its byte count equals the limit latched for it. The written-back length equals that limit, and neither the last-in-frame flag (status bit 11) nor the error flag (status bit 1) is set unless the closing byte carried that marker.
- R2: A byte marked end-of-frame closes the buffer after being stored, setting status bit 11. A byte marked error closes it after being stored, setting status bit 1. The length written back counts every byte stored, including the closing byte.
- R3: The write-back is one full-word write to the descriptor's first word. Bits 31:16 are the fetched status with bit 15 (empty) cleared and all other fetched bits kept. Bits 15:0 are the byte count.
- R4: After closing a descriptor whose status bit 13 (wrap) is set, the next descriptor read is at the table base. Otherwise it is at the current descriptor address plus 8.
- R5: Requesting enable with a table base whose low three bits are not zero keeps rx_on_o low and raises cfg_err_o.
- R6: Requesting enable with a zero maximum length, or with an odd one while wide_char_i is high, keeps rx_on_o low and raises cfg_err_o. A legal configuration enables with cfg_err_o low.
- R7: A maximum-length write made while a buffer is being filled does not change that buffer's limit. It applies from the next descriptor taken.
- R8: A table-base write (cfg_sel_i low) while the receiver is on is ignored.
- R9: If a fetched descriptor has bit 15 clear, busy_o rises. Bytes are then accepted and dropped without any memory write. The descriptor is re-read until its bit 15 is set, at which point busy_o falls and filling resumes at that buffer's start.
- R10: Bytes are stored at consecutive byte addresses from the descriptor's pointer word. Each byte uses one write with a single byte enable, where byte address offset 0 within a word maps to bits 31:24 (enable bit 3).
- R11: After reset, rx_on_o, busy_o, cfg_err_o and mem_req_o are low. Dropping rx_en_i and raising it again restarts the ring at the table base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0: table base, 1: maximum buffer length |
| cfg_wdata_i | input | CW | Configuration write value |
| rx_en_i | input | 1 | Receiver enable request |
| wide_char_i | input | 1 | Characters wider than 8 bits (length must be even) |
| byte_valid_i | input | 1 | Received byte present |
| byte_data_i | input | 8 | Received byte |
| byte_eof_i | input | 1 | Byte ends a frame |
| byte_err_i | input | 1 | Byte received with an error |
| byte_ready_o | output | 1 | Byte taken on this edge when valid |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (else read, data next cycle) |
| mem_addr_o | output | AW | Memory byte address |
| mem_be_o | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after request |
| rx_on_o | output | 1 | Receiver running |
| busy_o | output | 1 | No empty descriptor, bytes being dropped |
| cfg_err_o | output | 1 | Enable refused for an illegal configuration |

## Verification
A wrong descriptor pointer shows up at the first write-back or byte write after it goes wrong, as an access to the wrong descriptor or buffer address within a few cycles of the closing byte. A wrong count or latched limit shows up as a buffer that closes a byte early or late, visible in the length field of that buffer's write-back. A stale busy state shows up either as bytes landing in memory while busy_o is high, or as a buffer whose first byte is one that should have been dropped.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_STAT,
    ST_RD_PTR,
    ST_PTR_CAP,
    ST_FILL,
    ST_WB
  } seq_state_e;

  localparam int unsigned BIT_EMPTY  = 15;
  localparam int unsigned BIT_WRAP   = 13;
  localparam int unsigned BIT_LAST   = 11;
  localparam int unsigned BIT_ERR    = 1;
  localparam int unsigned DESC_BYTES = 8;
  localparam int unsigned PTR_OFFS   = 4;
endpackage

// File: rtl/rxbd_cfg.sv
module rxbd_cfg #(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          cfg_sel_i,
  input  logic [CW-1:0] cfg_wdata_i,
  input  logic          rx_en_i,
  input  logic          wide_char_i,
  output logic [AW-1:0] base_o,
  output logic [LW-1:0] mrblr_o,
  output logic          rx_on_o,
  output logic          cfg_err_o
);
  logic [AW-1:0] base_q;
  logic [LW-1:0] mrblr_q;
  logic          rx_on_q;
  logic          cfg_ok;

  assign cfg_ok = (base_q[2:0] == 3'b000) && (mrblr_q != '0) &&
                  !(wide_char_i && mrblr_q[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      mrblr_q <= '0;
      rx_on_q <= 1'b0;
    end else begin
      // base locked while running; length always taken, applied at next fetch
      if (cfg_we_i && !cfg_sel_i && !rx_on_q) base_q <= cfg_wdata_i[AW-1:0];
      if (cfg_we_i && cfg_sel_i) mrblr_q <= cfg_wdata_i[LW-1:0];
      rx_on_q <= rx_en_i && (rx_on_q || cfg_ok);
    end
  end

  assign base_o    = base_q;
  assign mrblr_o   = mrblr_q;
  assign rx_on_o   = rx_on_q;
  assign cfg_err_o = rx_en_i && !rx_on_q && !cfg_ok;
endmodule

// File: rtl/rxbd_dptr.sv
module rxbd_dptr #(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [LW-1:0] lim_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o,
  output logic [LW-1:0] cnt_o,
  output logic [LW-1:0] lim_o,
  output logic          last_o
);
  logic [AW-1:0] ptr_q;
  logic [LW-1:0] cnt_q;
  logic [LW-1:0] lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
      lim_q <= '0;
    end else if (load_i) begin
      ptr_q <= ptr_i;
      cnt_q <= '0;
      lim_q <= lim_i;
    end else if (step_i) begin
      ptr_q <= ptr_q + AW'(1);
      cnt_q <= cnt_q + LW'(1);
    end
  end

  // this step reaches the limit
  assign last_o = ({1'b0, cnt_q} + (LW+1)'(1)) == {1'b0, lim_q};
  assign ptr_o  = ptr_q;
  assign cnt_o  = cnt_q;
  assign lim_o  = lim_q;
endmodule

// File: rtl/rxbd_ctl.sv
module rxbd_ctl
  import rxbd_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_on_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] mrblr_i,
  input  logic          byte_valid_i,
  input  logic [7:0]    byte_data_i,
  input  logic          byte_eof_i,
  input  logic          byte_err_i,
  output logic          byte_ready_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [3:0]    mem_be_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          busy_o,
  output logic          fill_o,
  output logic          dp_load_o,
  output logic [AW-1:0] dp_ptr_o,
  output logic [LW-1:0] dp_lim_o,
  output logic          dp_step_o,
  input  logic [AW-1:0] dp_ptr_i,
  input  logic [LW-1:0] dp_cnt_i,
  input  logic          dp_last_i
);
  seq_state_e    state_q, state_d;
  logic [AW-1:0] desc_q;
  logic [15:0]   stat_q;
  logic          busy_q;
  logic          eof_q, err_q;
  logic          take;
  logic          closing;
  logic [15:0]   stat_wb;

  assign take    = (state_q == ST_FILL) && byte_valid_i;
  assign closing = take && (byte_eof_i || byte_err_i || dp_last_i);

  always_comb begin
    stat_wb            = stat_q;
    stat_wb[BIT_EMPTY] = 1'b0;
    if (eof_q) stat_wb[BIT_LAST] = 1'b1;
    if (err_q) stat_wb[BIT_ERR]  = 1'b1;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (rx_on_i) state_d = ST_RD_STAT;
      ST_RD_STAT: state_d = ST_RD_PTR;
      ST_RD_PTR:  state_d = ST_PTR_CAP;
      ST_PTR_CAP: state_d = stat_q[BIT_EMPTY] ? ST_FILL : ST_RD_STAT;
      ST_FILL:    if (closing) state_d = ST_WB;
      ST_WB:      state_d = ST_RD_STAT;
      default:    state_d = ST_IDLE;
    endcase
    if (!rx_on_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      desc_q  <= '0;
      stat_q  <= '0;
      busy_q  <= 1'b0;
      eof_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (!rx_on_i || state_q == ST_IDLE) begin
        desc_q <= base_i;
        busy_q <= 1'b0;
      end else begin
        if (state_q == ST_RD_PTR) stat_q <= mem_rdata_i[31:16];
        if (state_q == ST_PTR_CAP) busy_q <= !stat_q[BIT_EMPTY];
        if (closing) begin
          eof_q <= byte_eof_i;
          err_q <= byte_err_i;
        end
        if (state_q == ST_WB)
          desc_q <= stat_q[BIT_WRAP] ? base_i : desc_q + AW'(DESC_BYTES);
      end
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = desc_q;
    mem_be_o    = 4'h0;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_RD_STAT: mem_req_o = 1'b1;
      ST_RD_PTR: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_q + AW'(PTR_OFFS);
      end
      ST_FILL: if (byte_valid_i) begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = dp_ptr_i;
        mem_be_o    = 4'b1000 >> dp_ptr_i[1:0];
        mem_wdata_o = {4{byte_data_i}};
      end
      ST_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_be_o    = 4'hF;
        mem_wdata_o = {stat_wb, 16'(dp_cnt_i)};
      end
      default: ;
    endcase
  end

  assign byte_ready_o = (state_q == ST_FILL) || busy_q;
  assign busy_o       = busy_q;
  assign fill_o       = (state_q == ST_FILL);
  assign dp_load_o    = (state_q == ST_PTR_CAP) && stat_q[BIT_EMPTY];
  assign dp_ptr_o     = mem_rdata_i[AW-1:0];
  assign dp_lim_o     = mrblr_i;
  assign dp_step_o    = take;
endmodule

// File: rtl/rx_bd_seq.sv
module rx_bd_seq #(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 16,
  parameter int unsigned CW = (AW > LW) ? AW : LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          cfg_sel_i,
  input  logic [CW-1:0] cfg_wdata_i,
  input  logic          rx_en_i,
  input  logic          wide_char_i,
  input  logic          byte_valid_i,
  input  logic [7:0]    byte_data_i,
  input  logic          byte_eof_i,
  input  logic          byte_err_i,
  output logic          byte_ready_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [3:0]    mem_be_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          rx_on_o,
  output logic          busy_o,
  output logic          cfg_err_o
);
  logic [AW-1:0] base_q;
  logic [LW-1:0] mrblr_q;
  logic          rx_on;
  logic          in_fill;
  logic          dp_load, dp_step, dp_last;
  logic [AW-1:0] dp_ld_ptr, dp_ptr;
  logic [LW-1:0] dp_ld_lim, dp_cnt, dp_lim;

  rxbd_cfg #(.AW(AW), .LW(LW), .CW(CW)) cfg_i (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_wdata_i, .rx_en_i, .wide_char_i,
    .base_o(base_q), .mrblr_o(mrblr_q), .rx_on_o(rx_on), .cfg_err_o(cfg_err_o)
  );

  rxbd_dptr #(.AW(AW), .LW(LW)) dptr_i (
    .clk_i, .rst_ni, .load_i(dp_load), .ptr_i(dp_ld_ptr), .lim_i(dp_ld_lim),
    .step_i(dp_step), .ptr_o(dp_ptr), .cnt_o(dp_cnt), .lim_o(dp_lim), .last_o(dp_last)
  );

  rxbd_ctl #(.AW(AW), .LW(LW)) ctl_i (
    .clk_i, .rst_ni, .rx_on_i(rx_on), .base_i(base_q), .mrblr_i(mrblr_q),
    .byte_valid_i, .byte_data_i, .byte_eof_i, .byte_err_i, .byte_ready_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_be_o, .mem_wdata_o, .mem_rdata_i,
    .busy_o, .fill_o(in_fill),
    .dp_load_o(dp_load), .dp_ptr_o(dp_ld_ptr), .dp_lim_o(dp_ld_lim), .dp_step_o(dp_step),
    .dp_ptr_i(dp_ptr), .dp_cnt_i(dp_cnt), .dp_last_i(dp_last)
  );

  assign rx_on_o = rx_on;
endmodule

// File: rtl/rx_bd_seq_chk.sv
module rx_bd_seq_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_on_o,
  input logic          busy_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [3:0]    mem_be_o,
  input logic [31:0]   mem_wdata_o,
  input logic [AW-1:0] base_q,
  input logic [LW-1:0] mrblr_q,
  input logic          in_fill,
  input logic [LW-1:0] dp_cnt,
  input logic [LW-1:0] dp_lim
);
  assert_base_aligned_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_on_o |-> base_q[2:0] == 3'b000);

  assert_count_below_limit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fill |-> dp_cnt < dp_lim);

  assert_limit_latched_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_fill) |-> dp_lim == $past(mrblr_q));

  assert_wb_empty_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_be_o == 4'hF) |-> !mem_wdata_o[31]);

  assert_single_lane_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_be_o != 4'hF) |-> $onehot(mem_be_o));

  assert_no_store_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(mem_req_o && mem_we_o && mem_be_o != 4'hF));

  assert_desc_read_aligned_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> mem_addr_o[1:0] == 2'b00);
endmodule

bind rx_bd_seq rx_bd_seq_chk #(.AW(AW), .LW(LW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_on_o(rx_on_o), .busy_o(busy_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .base_q(base_q),
  .mrblr_q(mrblr_q), .in_fill(in_fill), .dp_cnt(dp_cnt), .dp_lim(dp_lim)
);

// File: tb/rx_bd_seq_tb_top.sv
`timescale 1ns/1ps
module rx_bd_seq_tb_top;
  localparam int unsigned AW = 16;
  localparam int unsigned LW = 16;
  localparam int unsigned CW = 16;
  localparam logic [15:0] BASE = 16'h0100;

  // {bytes[31:24], kind[23:16] 0 none/1 eof/2 err, expected status[15:0]}
  localparam logic [31:0] VEC [5] = '{
    {8'd4, 8'd0, 16'h0000},
    {8'd2, 8'd1, 16'h0800},
    {8'd3, 8'd2, 16'h2002},
    {8'd1, 8'd1, 16'h0800},
    {8'd4, 8'd1, 16'h0800}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [CW-1:0] cfg_wdata = '0;
  logic rx_en = 1'b0, wide_char = 1'b0;
  logic byte_valid = 1'b0, byte_eof = 1'b0, byte_err = 1'b0;
  logic [7:0] byte_data = '0;
  logic byte_ready_o, mem_req_o, mem_we_o, rx_on_o, busy_o, cfg_err_o;
  logic [AW-1:0] mem_addr_o;
  logic [3:0] mem_be_o;
  logic [31:0] mem_wdata_o;
  logic [31:0] mem_rdata;
  logic [31:0] mem [256];
  logic tb_we = 1'b0;
  logic [15:0] tb_a = '0;
  logic [31:0] tb_d = '0;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_bd_seq #(.AW(AW), .LW(LW), .CW(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .rx_en_i(rx_en), .wide_char_i(wide_char),
    .byte_valid_i(byte_valid), .byte_data_i(byte_data), .byte_eof_i(byte_eof),
    .byte_err_i(byte_err), .byte_ready_o(byte_ready_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata), .rx_on_o(rx_on_o),
    .busy_o(busy_o), .cfg_err_o(cfg_err_o)
  );

  always @(posedge clk) begin
    if (tb_we) mem[tb_a[9:2]] <= tb_d;
    if (mem_req_o && mem_we_o) begin
      for (int l = 0; l < 4; l++)
        if (mem_be_o[l]) mem[mem_addr_o[9:2]][8*l +: 8] <= mem_wdata_o[8*l +: 8];
    end else if (mem_req_o) begin
      mem_rdata <= mem[mem_addr_o[9:2]];
    end
  end

  function automatic logic [15:0] daddr(input int d);
    return BASE + 16'(8 * d);
  endfunction
  function automatic logic [15:0] baddr(input int d);
    return 16'h0200 + 16'(64 * d);
  endfunction
  function automatic logic [7:0] rd_byte(input logic [15:0] a);
    return mem[a[9:2]][8*(3 - int'(a[1:0])) +: 8];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poke(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_a = a; tb_d = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic arm(input int d);
    poke(daddr(d), {(d == 2) ? 16'hA000 : 16'h8000, 16'h0000});
    poke(daddr(d) + 16'd4, {16'h0000, baddr(d)});
  endtask

  task automatic cfg(input logic sel, input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input logic e, input logic r);
    @(negedge clk);
    while (!byte_ready_o) @(negedge clk);
    byte_valid = 1'b1; byte_data = d; byte_eof = e; byte_err = r;
    @(negedge clk);
    byte_valid = 1'b0; byte_eof = 1'b0; byte_err = 1'b0;
  endtask

  task automatic check_desc(input string req, input int d, input logic [15:0] len,
                            input logic [15:0] st);
    check(req, {16'h0, mem[daddr(d) >> 2][15:0]}, {16'h0, len});
    check(req, {16'h0, mem[daddr(d) >> 2][31:16]}, {16'h0, st});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    int cur;
    wait_n(3);
    // R11: reset state
    check("R11", {28'h0, rx_on_o, busy_o, cfg_err_o, mem_req_o}, 32'h0);
    rst_ni = 1'b1;
    for (int d = 0; d < 3; d++) arm(d);

    // R5: misaligned base
    cfg(1'b0, BASE + 16'd4); cfg(1'b1, 16'd4);
    rx_en = 1'b1; wait_n(3);
    check("R5", {30'h0, rx_on_o, cfg_err_o}, 32'h1);
    rx_en = 1'b0; wait_n(2);
    // R6: zero length, then odd length with wide characters
    cfg(1'b0, BASE); cfg(1'b1, 16'd0);
    rx_en = 1'b1; wait_n(3);
    check("R6", {30'h0, rx_on_o, cfg_err_o}, 32'h1);
    rx_en = 1'b0; wide_char = 1'b1; cfg(1'b1, 16'd3);
    rx_en = 1'b1; wait_n(3);
    check("R6", {30'h0, rx_on_o, cfg_err_o}, 32'h1);
    rx_en = 1'b0; cfg(1'b1, 16'd4);
    rx_en = 1'b1; wait_n(3);
    check("R6", {30'h0, rx_on_o, cfg_err_o}, 32'h2);

    // table walk: limit 4, three-descriptor ring
    for (int i = 0; i < 5; i++) begin
      int n, kind, d, mism;
      n = int'(VEC[i][31:24]); kind = int'(VEC[i][23:16]); d = i % 3;
      if (i == 3) cfg(1'b0, 16'h0200);  // R8: ignored while running
      for (int k = 0; k < n; k++)
        send(8'(16 * i + k + 1), (k == n - 1) && kind == 1, (k == n - 1) && kind == 2);
      wait_n(6);
      // R1 limit close, R2 early close, R3 write-back, R4 wrap (i==3), R8 base kept
      check_desc(i == 0 ? "R1" : i == 2 ? "R2" : i == 3 ? "R4" : "R3", d,
                 16'(n), VEC[i][15:0]);
      mism = 0;
      for (int k = 0; k < n; k++)
        if (rd_byte(baddr(d) + 16'(k)) !== 8'(16 * i + k + 1)) mism++;
      check("R10", mism, 0);
      arm(d);
    end
    check("R8", {16'h0, mem[daddr(0) >> 2][15:0]}, 32'h0000);  // re-armed d0 not yet used
    cur = 2;

    // R7: length write mid-buffer applies to the next descriptor only
    send(8'h11, 1'b0, 1'b0);
    cfg(1'b1, 16'd2);
    for (int k = 0; k < 3; k++) send(8'h12 + 8'(k), 1'b0, 1'b0);
    wait_n(6);
    check_desc("R7", cur, 16'd4, 16'h2000);
    arm(cur); cur = 0;
    send(8'h21, 1'b0, 1'b0); send(8'h22, 1'b0, 1'b0);
    wait_n(6);
    check_desc("R7", cur, 16'd2, 16'h0000);
    arm(cur); cur = 1;

    // R9: next descriptor still owned by software
    poke(daddr(2), {16'h2000, 16'h0000});
    send(8'h31, 1'b0, 1'b0); send(8'h32, 1'b0, 1'b0);
    wait_n(6);
    check_desc("R1", cur, 16'd2, 16'h0000);
    arm(cur);
    check("R9", {31'h0, busy_o}, 32'h1);
    send(8'hEE, 1'b0, 1'b0); send(8'hEF, 1'b1, 1'b0);
    wait_n(2);
    check("R9", {16'h0, mem[daddr(2) >> 2][31:16]}, 32'h2000);
    arm(2); wait_n(6);
    check("R9", {31'h0, busy_o}, 32'h0);
    send(8'h5A, 1'b1, 1'b0);
    wait_n(6);
    check_desc("R9", 2, 16'd1, 16'h2800);
    check("R9", {24'h0, rd_byte(baddr(2))}, 32'h5A);
    arm(2); cur = 0;

    // R11: disable mid-ring restarts at base
    send(8'h41, 1'b1, 1'b0);
    wait_n(6);
    check_desc("R2", 0, 16'd1, 16'h0800);
    arm(0);
    rx_en = 1'b0; wait_n(3);
    check("R11", {31'h0, rx_on_o}, 32'h0);
    rx_en = 1'b1;
    send(8'h77, 1'b1, 1'b0);
    wait_n(6);
    check_desc("R11", 0, 16'd1, 16'h0800);
    check("R11", {24'h0, rd_byte(baddr(0))}, 32'h77);
    report();
  end
endmodule